// File: doc/BRIEF.md
# Unaligned Memory Access Controller

This controller connects a processor load/store port to a 32-bit memory made of four byte lanes. It accepts byte, halfword and word requests at any byte address. A request that runs past the end of its aligned word becomes two memory accesses: one to the word that holds the start address, and one to the following word.

For each access the block drives the word address, a chip enable, per-lane write enables, a rotate amount for the right-rotating data path, a flag marking the second access and a flag showing that the request needs two accesses. Load data is taken from the four lanes, rotated, merged across the two accesses and zero-extended before it is returned. A request with the reserved size code produces an error response and no memory access.

The memory read path is combinational. Read data for the word on `mem_word` is present on `mem_rdata` in the same cycle, and the controller samples it at the clock edge that ends that access cycle.

Top module: `unaligned_mem_ctrl`

## Requirements
- R1: After reset, `ready` is 1 and `mem_en`, `mem_cs`, `mem_we`, `second_acc`, `split`, `rsp_valid` and `err` are all 0.
- R2: `req_size` is decoded as 00 = 1 byte, 01 = 2 bytes, 10 = 4 bytes. `split` is 1 during the access cycles of a request exactly when offset (`req_addr[1:0]`) plus the byte count exceeds 4.
- R3: The first access drives `mem_word` = `req_addr[28:2]` with `second_acc` = 0. For a split request, the next cycle is a second access to `req_addr[28:2]`+1 (27-bit wrap) with `second_acc` = 1.
- R4: While `mem_en` is 1, `mem_cs` equals bit 28 of the accessed byte address, which is the top bit of `mem_word`. Outside access cycles, `mem_cs` is 0.
- R5: For a store, let the lane mask be 0001, 0011 or 1111 for byte, halfword or word, shifted left by the offset into 8 bits. The first access writes the lanes in bits 3:0 of that mask and the second access writes the lanes in bits 7:4. `mem_we` is 0 on loads and outside access cycles.
- R6: On store accesses, store byte k appears on lane (offset+k) mod 4 of `mem_wdata`, and `rot_amt` is (4−offset) mod 4. `mem_wdata` is 0 when no store access is in progress.
- R7: On load accesses, `rot_amt` equals the offset. In the response, byte i of `rsp_data` is the memory byte at address `req_addr`+i for i below the byte count, and 0 above it. A byte whose address has bit 28 low reads as 0, because the memory does not drive the bus then.
- R8: Size code 11 causes no memory access. The cycle after acceptance is a one-cycle response with `err` = 1 and `rsp_data` = 0.
- R9: A request is taken when `req_valid` and `ready` are both 1, and `ready` is 1 only when the block is idle. Access cycles follow directly. `rsp_valid` is high for exactly one cycle, right after the last access, and `rsp_data` is 0 for stores.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = store, 0 = load |
| req_size | input | 2 | Size code |
| req_addr | input | 29 | Byte address |
| req_wdata | input | 32 | Store data, right-justified |
| ready | output | 1 | Idle, request may be taken |
| mem_en | output | 1 | Memory access this cycle |
| mem_cs | output | 1 | Chip enable from address bit 28 |
| mem_word | output | 27 | Word address of the access |
| mem_we | output | 4 | Per-lane write enables |
| mem_wdata | output | 32 | Rotated store data |
| mem_rdata | input | 32 | Memory read data for `mem_word` |
| rot_amt | output | 2 | Right-rotate amount in bytes |
| second_acc | output | 1 | Current access is the second one |
| split | output | 1 | Request needs two accesses |
| rsp_valid | output | 1 | Response cycle |
| rsp_data | output | 32 | Aligned, zero-extended load result |
| err | output | 1 | Illegal size code response |

## Verification
The hardest case to bring about is a split access in which the two words straddle the bit-28 boundary. The chip enable then changes between the first and second access, and the word address wraps. The stimulus reaches it by aiming halfword and word requests at the last bytes of the address space, so the second access lands on word 0. It also covers every size at every offset, both inside and outside the chip-enabled half, and follows each store with a load of the same bytes so that lane merging is observed at the response port.

// File: rtl/unaligned_mem_ctrl.sv
module unaligned_mem_ctrl #(
  parameter int ADDR_W = 29
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [1:0]        req_size,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [31:0]       req_wdata,
  output logic              ready,
  output logic              mem_en,
  output logic              mem_cs,
  output logic [ADDR_W-3:0] mem_word,
  output logic [3:0]        mem_we,
  output logic [31:0]       mem_wdata,
  input  logic [31:0]       mem_rdata,
  output logic [1:0]        rot_amt,
  output logic              second_acc,
  output logic              split,
  output logic              rsp_valid,
  output logic [31:0]       rsp_data,
  output logic              err
);
  localparam int WORD_W = ADDR_W - 2;

  typedef enum logic [1:0] {IDLE, ACC1, ACC2, RESP} state_t;

  state_t            state;
  logic              wr_q, err_q;
  logic [1:0]        sz_q, off_q;
  logic [WORD_W-1:0] base_q;
  logic [31:0]       wdat_q, acc_q;

  function automatic logic [31:0] rotr(input logic [31:0] x, input logic [1:0] k);
    logic [63:0] d;
    d = {x, x} >> {k, 3'b000};
    return d[31:0];
  endfunction

  function automatic logic [31:0] lanes(input logic [3:0] m);
    return {{8{m[3]}}, {8{m[2]}}, {8{m[1]}}, {8{m[0]}}};
  endfunction

  logic [3:0]  sz_mask;
  logic [7:0]  span;
  logic        need2, accept;
  logic [31:0] rd_rot, lo_keep;

  assign sz_mask = (sz_q == 2'b00) ? 4'h1 : (sz_q == 2'b01) ? 4'h3 : 4'hF;
  assign span    = {4'b0000, sz_mask} << off_q;
  assign need2   = |span[7:4];
  assign accept  = req_valid && ready;

  assign ready      = (state == IDLE);
  assign mem_en     = (state == ACC1) || (state == ACC2);
  assign second_acc = (state == ACC2);
  assign split      = mem_en && need2;
  assign mem_word   = !mem_en ? '0 : second_acc ? base_q + 1'b1 : base_q;
  assign mem_cs     = mem_en && mem_word[WORD_W-1];
  assign rot_amt    = !mem_en ? 2'b00 : wr_q ? 2'b00 - off_q : off_q;
  assign mem_we     = !(mem_en && wr_q) ? 4'h0 : second_acc ? span[7:4] : span[3:0];
  assign mem_wdata  = (mem_en && wr_q) ? rotr(wdat_q, rot_amt) : 32'h0;

  assign rd_rot  = rotr(mem_rdata, off_q);
  assign lo_keep = lanes(4'hF >> off_q);

  assign rsp_valid = (state == RESP);
  assign err       = rsp_valid && err_q;
  assign rsp_data  = (rsp_valid && !wr_q && !err_q) ? (acc_q & lanes(sz_mask)) : 32'h0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= IDLE;
      wr_q   <= 1'b0;
      err_q  <= 1'b0;
      sz_q   <= 2'b00;
      off_q  <= 2'b00;
      base_q <= '0;
      wdat_q <= 32'h0;
      acc_q  <= 32'h0;
    end else begin
      case (state)
        IDLE: if (accept) begin
          wr_q   <= req_write;
          err_q  <= (req_size == 2'b11);
          sz_q   <= req_size;
          off_q  <= req_addr[1:0];
          base_q <= req_addr[ADDR_W-1:2];
          wdat_q <= req_wdata;
          state  <= (req_size == 2'b11) ? RESP : ACC1;
        end
        ACC1: begin
          acc_q <= rd_rot;
          state <= need2 ? ACC2 : RESP;
        end
        ACC2: begin
          acc_q <= (acc_q & lo_keep) | (rd_rot & ~lo_keep);
          state <= RESP;
        end
        default: state <= IDLE;
      endcase
    end
  end
endmodule

// File: rtl/unaligned_mem_ctrl_chk.sv
module unaligned_mem_ctrl_chk #(
  parameter int WORD_W = 27
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ready,
  input logic              mem_en,
  input logic [WORD_W-1:0] mem_word,
  input logic [3:0]        mem_we,
  input logic              second_acc,
  input logic              split,
  input logic              rsp_valid,
  input logic              err
);
  a_r9_rsp_single: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> (!mem_en && !rsp_valid));

  a_r3_second_follows_first: assert property (@(posedge clk) disable iff (!rst_n)
    second_acc |-> ($past(mem_en) && !$past(second_acc)));

  a_r3_next_word: assert property (@(posedge clk) disable iff (!rst_n)
    second_acc |-> (mem_word == $past(mem_word) + 1'b1));

  a_r2_second_only_split: assert property (@(posedge clk) disable iff (!rst_n)
    second_acc |-> split);

  a_r5_first_reaches_top: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_en && !second_acc && split && (mem_we != 4'h0)) |-> mem_we[3]);

  a_r5_second_from_lane0: assert property (@(posedge clk) disable iff (!rst_n)
    (second_acc && (mem_we != 4'h0)) |-> (mem_we[0] && !mem_we[3]));

  a_r8_err_without_access: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> !$past(mem_en));
endmodule

bind unaligned_mem_ctrl unaligned_mem_ctrl_chk #(.WORD_W(ADDR_W - 2)) u_chk (
  .clk(clk), .rst_n(rst_n), .ready(ready), .mem_en(mem_en), .mem_word(mem_word),
  .mem_we(mem_we), .second_acc(second_acc), .split(split),
  .rsp_valid(rsp_valid), .err(err)
);

// File: tb/unaligned_mem_ctrl_test.sv
module unaligned_mem_ctrl_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [1:0]  req_size = 2'b00;
  logic [28:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        ready, mem_en, mem_cs, second_acc, split, rsp_valid, err;
  logic [26:0] mem_word;
  logic [3:0]  mem_we;
  logic [31:0] mem_wdata, mem_rdata, rsp_data;
  logic [1:0]  rot_amt;

  int checks = 0, failures = 0;
  logic [7:0]   mem [256];
  logic [103:0] expq [$];
  string        tagq [$];

  always #(CLK_PERIOD/2) clk = ~clk;

  unaligned_mem_ctrl uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_size(req_size), .req_addr(req_addr), .req_wdata(req_wdata),
    .ready(ready), .mem_en(mem_en), .mem_cs(mem_cs), .mem_word(mem_word),
    .mem_we(mem_we), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .rot_amt(rot_amt), .second_acc(second_acc), .split(split),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .err(err)
  );

  assign mem_rdata = mem_cs ? {mem[{mem_word[5:0], 2'd3}], mem[{mem_word[5:0], 2'd2}],
                               mem[{mem_word[5:0], 2'd1}], mem[{mem_word[5:0], 2'd0}]} : 32'h0;

  always @(posedge clk)
    if (mem_en && mem_cs)
      for (int l = 0; l < 4; l++)
        if (mem_we[l]) mem[{mem_word[5:0], 2'(l)}] <= mem_wdata[8*l +: 8];

  function automatic logic [103:0] pack(logic rd, logic en, logic cs, logic sec, logic spl,
                                        logic rsp, logic er, logic [26:0] w, logic [3:0] we,
                                        logic [1:0] rot, logic [31:0] wd, logic [31:0] rdat);
    return {rd, en, cs, sec, spl, rsp, er, w, we, rot, wd, rdat};
  endfunction

  task automatic tick();
    logic [103:0] got, e;
    string t;
    @(negedge clk);
    got = pack(ready, mem_en, mem_cs, second_acc, split, rsp_valid, err,
               mem_word, mem_we, rot_amt, mem_wdata, rsp_data);
    if (expq.size() > 0) begin
      e = expq.pop_front();
      t = tagq.pop_front();
    end else begin
      e = pack(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, '0, 4'h0, 2'b00, 32'h0, 32'h0);
      t = rst_n ? "R9 idle" : "R1 reset";
    end
    checks++;
    if (got !== e) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", t, got, e);
    end
  endtask

  task automatic issue(input logic w, input logic [1:0] s, input logic [28:0] a,
                       input logic [31:0] d);
    int o, n;
    logic [7:0]  span;
    logic [26:0] w0, w1;
    logic [1:0]  rot;
    logic [31:0] wd, rd;
    logic        spl;
    logic [28:0] ba;
    o = int'(a[1:0]);
    n = (s == 2'b00) ? 1 : (s == 2'b01) ? 2 : 4;
    span = ((s == 2'b00) ? 8'h01 : (s == 2'b01) ? 8'h03 : 8'h0F) << o;
    spl  = (o + n) > 4;
    w0 = a[28:2];
    w1 = w0 + 27'd1;
    req_valid = 1'b1; req_write = w; req_size = s; req_addr = a; req_wdata = d;
    if (s == 2'b11) begin
      expq.push_back(pack(0, 0, 0, 0, 0, 1, 1, '0, 4'h0, 2'b00, 32'h0, 32'h0));
      tagq.push_back("R8 illegal size");
    end else begin
      rot = w ? 2'((4 - o) % 4) : 2'(o);
      wd = 32'h0;
      if (w) for (int l = 0; l < 4; l++) wd[8*l +: 8] = d[8*((l - o + 4) % 4) +: 8];
      expq.push_back(pack(0, 1, w0[26], 0, spl, 0, 0, w0, w ? span[3:0] : 4'h0, rot, wd, 32'h0));
      tagq.push_back(w ? "R2/R3/R4/R5/R6 first store access" : "R2/R3/R4/R7 first load access");
      if (spl) begin
        expq.push_back(pack(0, 1, w1[26], 1, 1, 0, 0, w1, w ? span[7:4] : 4'h0, rot, wd, 32'h0));
        tagq.push_back("R3/R4/R5 second access");
      end
      rd = 32'h0;
      if (!w) for (int i = 0; i < n; i++) begin
        ba = a + 29'(i);
        rd[8*i +: 8] = ba[28] ? mem[ba[7:0]] : 8'h00;
      end
      expq.push_back(pack(0, 0, 0, 0, 0, 1, 0, '0, 4'h0, 2'b00, 32'h0, rd));
      tagq.push_back(w ? "R9 store response" : "R7 load response");
    end
    tick();
    req_valid = 1'b0;
    while (expq.size() > 0) tick();
    tick();
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    failures++;
    $display("FAIL R9 watchdog actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [31:0] r;
    for (int i = 0; i < 256; i++) mem[i] = 8'(i * 7 + 3);
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    for (int s = 0; s < 3; s++)
      for (int o = 0; o < 4; o++) begin
        issue(1'b1, 2'(s), 29'h1000_0040 + 29'(o), 32'hA1B2_C3D4 + 32'(o * 16 + s));
        issue(1'b0, 2'(s), 29'h1000_0040 + 29'(o), 32'h0);
        issue(1'b0, 2'(s), 29'h0000_0080 + 29'(o), 32'h0);
      end
    issue(1'b1, 2'b10, 29'h1FFF_FFFE, 32'h1122_3344);
    issue(1'b0, 2'b10, 29'h1FFF_FFFE, 32'h0);
    issue(1'b0, 2'b01, 29'h1FFF_FFFF, 32'h0);
    issue(1'b1, 2'b01, 29'h0FFF_FFFF, 32'h5566_7788);
    issue(1'b0, 2'b11, 29'h1000_0001, 32'h0);
    issue(1'b1, 2'b11, 29'h1000_0002, 32'hFFFF_FFFF);
    issue(1'b0, 2'b10, 29'h1000_0040, 32'h0);
    for (int k = 0; k < 80; k++) begin
      r = $urandom;
      issue(r[0], r[2:1] == 2'b11 ? 2'b10 : r[2:1], {r[3], 20'h0, r[11:4]}, $urandom);
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule